// File: doc/BRIEF.md
# Adaptive Host Register Port

This block is the host-facing front end of a peripheral. A host processor reaches a small register file through it. The host may use either of two bus styles. In the first, separate active-low read and write strobes are used. In the second, an active-high data strobe is paired with a read/not-write direction line. The block works out which style the host uses, and which address scheme it uses, at the start of every access. It decides each one anew, so neither needs to be fixed at board design time. The shared strobe pin, sampled when chip select falls, picks the style. The address-latch pin, sampled at the same moment, picks between a multiplexed bus and a bus with a separate register-select field. On a multiplexed bus the register address arrives on the data lines.

Every host input passes through a two-stage synchronizer into the internal clock domain before any edge is detected. The register file holds four slots: a data slot, a control slot, a status slot and one reserved slot. The data slot sends written bytes out as transmit data and reads back the receive byte. The control slot can be both read and written. The status slot holds sticky event flags. These flags are set by the core side on any cycle, with no host activity needed. A host read of the status slot clears the flags it saw. The clear happens only once that read is over.

Top module: `adaptive_host_port`

## Requirements
- R1: After a synchronous reset, `dq_oe`, `tx_wr_o`, `ctrl_o`, `tx_data_o`, the status flags and the receive byte are all zero.
- R2: The level of `ds_rd` at the falling edge of `cs_n` sets the style for that access. A high level selects split strobes: `ds_rd` low reads and `wr_rw` low writes. A low level selects data-strobe style: `ds_rd` high is the strobe, and `wr_rw` high means read while `wr_rw` low means write.
- R3: If `ale` is high at the falling edge of `cs_n`, the register address is the low `ADDR_W` bits of `dq_in` at that edge, and `rsel` is ignored. Otherwise the address comes from `rsel` while the strobe is active.
- R4: A write takes effect on the trailing edge of the active write strobe. Address 0 loads `tx_data_o` and raises `tx_wr_o` for exactly one clock. Address 1 loads `ctrl_o`.
- R5: A read returns data by address: 0 gives the receive byte, 1 gives the control byte, 2 gives the status flags, and 3 gives zero.
- R6: `dq_oe` is high only while `cs_n` is low and the read strobe of the detected style is active. Strobes with `cs_n` high neither drive the bus nor write.
- R7: Each high bit of `evt_i` sets the matching status flag on the next clock, whether or not the host is active. A host write to address 2 leaves the flags unchanged.
- R8: A status read clears only those flags that were set when its read strobe began. The clear happens after the strobe ends. Flags stay visible for the whole read, and a flag raised during the read survives it.
- R9: A one-clock `rx_load_i` pulse stores `rx_data_i` as the receive byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ds_rd | input | 1 | Shared pin: read strobe (split style) or data strobe (strobe style) |
| wr_rw | input | 1 | Shared pin: write strobe (split style) or read/not-write (strobe style) |
| ale | input | 1 | Address-latch level; high at chip select fall marks a multiplexed bus |
| rsel | input | ADDR_W | Register select for a non-multiplexed bus |
| dq_in | input | DATA_W | Host data bus, input side |
| dq_out | output | DATA_W | Host data bus, output side |
| dq_oe | output | 1 | Output enable for the data bus drivers |
| ctrl_o | output | DATA_W | Control byte |
| tx_data_o | output | DATA_W | Last byte written to the data slot |
| tx_wr_o | output | 1 | One-clock pulse per data-slot write |
| rx_data_i | input | DATA_W | Receive byte from the core |
| rx_load_i | input | 1 | Loads the receive byte |
| evt_i | input | DATA_W | Event pulses that set the status flags |

## Verification
The bench runs writes and read-backs under all four pairings of bus style and address scheme. On multiplexed accesses it drives `rsel` to a wrong address, so a design that decoded the wrong source reads or writes the wrong slot. It drives strobes with chip select high, which a design that ignored chip select would answer by driving the bus or writing control. It raises one flag during a status read. A design that cleared the flags as the strobe began, or that cleared everything when the strobe ended, would either hide the flags from the host or lose the late one. It writes to the status slot and checks that the flags stay at zero.

// File: rtl/hbi_pkg.sv
// Shared types and slot numbers for the adaptive host register port.
// Assumes the slot numbers fit in the smallest ADDR_W the top accepts (2).
package hbi_pkg;

    // Host bus style, decided afresh at each chip-select fall.
    typedef enum logic {
        STYLE_DS_RW = 1'b0,   // data strobe high active, direction line
        STYLE_RD_WR = 1'b1    // split read and write strobes, low active
    } bus_style_e;

    // Register slots seen by the host.
    localparam int unsigned SLOT_DATA = 0;
    localparam int unsigned SLOT_CTRL = 1;
    localparam int unsigned SLOT_STAT = 2;

endpackage

// File: rtl/hbi_sync.sv
// Two-stage synchronizer for a bundle of asynchronous host inputs.
// Assumes every bit of the bundle is held steady across several clocks,
// so that the bits sampled on one edge form a coherent bundle.
module hbi_sync #(
    parameter int unsigned  W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two flops in series; both start at the idle level of the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;

endmodule

// File: rtl/hbi_cycle_track.sv
// Tracks host accesses. On each chip-select fall it records the bus style
// taken from the shared strobe pin, records whether the bus is multiplexed
// (taken from the address-latch level), and latches the address from the
// data lines when the bus is multiplexed. Assumes its inputs are already
// synchronized and share one latency.
module hbi_cycle_track
    import hbi_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              ds_rd_s,
    input  logic              ale_s,
    input  logic [DATA_W-1:0] dq_s,
    input  logic [ADDR_W-1:0] rsel_s,
    output logic              in_cycle,
    output bus_style_e        style,
    output logic              muxed,
    output logic [ADDR_W-1:0] addr_sel
);

    logic              cs_prev;
    logic              cs_fall;
    logic [ADDR_W-1:0] addr_lat;

    assign cs_fall = cs_prev & ~cs_s;

    // Remembers the previous chip-select level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_prev <= 1'b1;
        else        cs_prev <= cs_s;
    end

    // Opens an access on chip-select fall and closes it on chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n)       in_cycle <= 1'b0;
        else if (cs_fall) in_cycle <= 1'b1;
        else if (cs_s)    in_cycle <= 1'b0;
    end

    // Records bus style and address scheme once per access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            style <= STYLE_RD_WR;
            muxed <= 1'b0;
        end else if (cs_fall) begin
            style <= ds_rd_s ? STYLE_RD_WR : STYLE_DS_RW;
            muxed <= ale_s;
        end
    end

    // Captures the address from the data lines on a multiplexed bus.
    always_ff @(posedge clk) begin
        if (!rst_n)                 addr_lat <= '0;
        else if (cs_fall && ale_s)  addr_lat <= dq_s[ADDR_W-1:0];
    end

    // Chooses where the active address comes from.
    always_comb begin
        addr_sel = muxed ? addr_lat : rsel_s;
    end

endmodule

// File: rtl/hbi_strobe.sv
// Turns the synchronized shared pins into read and write activity for the
// style recorded at the start of the access. Gives one-clock start and end
// marks for reads and a commit mark at the trailing edge of a write. While
// the write strobe is active it keeps the last address and data, so a host
// that changes the bus as it releases the strobe still writes what it meant.
module hbi_strobe
    import hbi_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              ds_rd_s,
    input  logic              wr_rw_s,
    input  logic              in_cycle,
    input  bus_style_e        style,
    input  logic [ADDR_W-1:0] addr_sel,
    input  logic [DATA_W-1:0] dq_s,
    output logic              rd_act,
    output logic              rd_start,
    output logic              rd_end,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata
);

    logic rd_req;
    logic wr_req;
    logic wr_act;
    logic rd_prev;
    logic wr_prev;

    // Decodes the pins according to the recorded bus style.
    always_comb begin
        if (style == STYLE_RD_WR) begin
            rd_req = ~ds_rd_s;
            wr_req = ~wr_rw_s;
        end else begin
            rd_req = ds_rd_s & wr_rw_s;
            wr_req = ds_rd_s & ~wr_rw_s;
        end
        rd_act = in_cycle & ~cs_s & rd_req;
        wr_act = in_cycle & ~cs_s & wr_req;
    end

    // Remembers the previous activity levels for edge marks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
        end else begin
            rd_prev <= rd_act;
            wr_prev <= wr_act;
        end
    end

    // Keeps the address and data of the write in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr <= '0;
            wdata <= '0;
        end else if (wr_act) begin
            waddr <= addr_sel;
            wdata <= dq_s;
        end
    end

    assign rd_start  = rd_act & ~rd_prev;
    assign rd_end    = rd_prev & ~rd_act;
    assign wr_commit = wr_prev & ~wr_act;

endmodule

// File: rtl/hbi_regfile.sv
// The four host-visible slots: data (transmit on write, receive on read),
// control, sticky status and a reserved slot that reads zero. A status
// read snapshots the flags at its start and clears only that snapshot once
// the read ends. Events always win over a clear in the same clock.
module hbi_regfile
    import hbi_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_start,
    input  logic              rd_end,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [DATA_W-1:0] evt_i,
    input  logic              rx_load_i,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              tx_wr_o,
    output logic [DATA_W-1:0] status_q
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(SLOT_DATA);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(SLOT_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(SLOT_STAT);

    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] clr_mask;
    logic              clr_pend;
    logic [DATA_W-1:0] clr_now;

    // Applies host writes to the transmit and control slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o    <= '0;
            tx_data_o <= '0;
            tx_wr_o   <= 1'b0;
        end else begin
            tx_wr_o <= 1'b0;
            if (wr_commit && waddr == A_DATA) begin
                tx_data_o <= wdata;
                tx_wr_o   <= 1'b1;
            end
            if (wr_commit && waddr == A_CTRL) ctrl_o <= wdata;
        end
    end

    // Loads the receive byte from the core side.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_q <= '0;
        else if (rx_load_i) rx_q <= rx_data_i;
    end

    // Snapshots the flags the host sees when a status read starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_pend <= 1'b0;
            clr_mask <= '0;
        end else if (rd_start && raddr == A_STAT) begin
            clr_pend <= 1'b1;
            clr_mask <= status_q;
        end else if (rd_end) begin
            clr_pend <= 1'b0;
        end
    end

    assign clr_now = (rd_end && clr_pend) ? clr_mask : '0;

    // Sticky flags: set by events at any time, cleared only after a read.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_now) | evt_i;
    end

    // Selects the byte returned for the current address.
    always_comb begin
        unique case (raddr)
            A_DATA:  rdata = rx_q;
            A_CTRL:  rdata = ctrl_o;
            A_STAT:  rdata = status_q;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/adaptive_host_port.sv
// Top of the adaptive host register port. It synchronizes all host pins as
// one bundle so that their relative timing survives, tracks each access,
// decodes the strobes and serves the register file. The data bus is split
// into input, output and enable; the pad ring builds the tri-state driver.
// Assumes host pins are held steady for at least three clocks around every
// transition and that ADDR_W is at least 2 and no wider than DATA_W.
module adaptive_host_port
    import hbi_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ds_rd,
    input  logic              wr_rw,
    input  logic              ale,
    input  logic [ADDR_W-1:0] rsel,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              tx_wr_o,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              rx_load_i,
    input  logic [DATA_W-1:0] evt_i
);

    localparam int unsigned SYNC_W = 4 + ADDR_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_IDLE = {1'b1, 1'b1, 1'b1, 1'b0,
                                              {(ADDR_W + DATA_W){1'b0}}};

    logic [SYNC_W-1:0] pins_async;
    logic [SYNC_W-1:0] pins_sync;
    logic              cs_s;
    logic              ds_rd_s;
    logic              wr_rw_s;
    logic              ale_s;
    logic [ADDR_W-1:0] rsel_s;
    logic [DATA_W-1:0] dq_s;

    logic              in_cycle;
    bus_style_e        style;
    logic              muxed;
    logic [ADDR_W-1:0] addr_sel;
    logic              rd_act;
    logic              rd_start;
    logic              rd_end;
    logic              wr_commit;
    logic [ADDR_W-1:0] waddr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] status_w;

    assign pins_async = {cs_n, ds_rd, wr_rw, ale, rsel, dq_in};
    assign {cs_s, ds_rd_s, wr_rw_s, ale_s, rsel_s, dq_s} = pins_sync;

    hbi_sync #(
        .W       (SYNC_W),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pins_async),
        .q_sync  (pins_sync)
    );

    hbi_cycle_track #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (cs_s),
        .ds_rd_s  (ds_rd_s),
        .ale_s    (ale_s),
        .dq_s     (dq_s),
        .rsel_s   (rsel_s),
        .in_cycle (in_cycle),
        .style    (style),
        .muxed    (muxed),
        .addr_sel (addr_sel)
    );

    hbi_strobe #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .ds_rd_s   (ds_rd_s),
        .wr_rw_s   (wr_rw_s),
        .in_cycle  (in_cycle),
        .style     (style),
        .addr_sel  (addr_sel),
        .dq_s      (dq_s),
        .rd_act    (rd_act),
        .rd_start  (rd_start),
        .rd_end    (rd_end),
        .wr_commit (wr_commit),
        .waddr     (waddr),
        .wdata     (wdata)
    );

    hbi_regfile #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_commit (wr_commit),
        .waddr     (waddr),
        .wdata     (wdata),
        .rd_start  (rd_start),
        .rd_end    (rd_end),
        .raddr     (addr_sel),
        .evt_i     (evt_i),
        .rx_load_i (rx_load_i),
        .rx_data_i (rx_data_i),
        .rdata     (rdata),
        .ctrl_o    (ctrl_o),
        .tx_data_o (tx_data_o),
        .tx_wr_o   (tx_wr_o),
        .status_q  (status_w)
    );

    // Drives read data only while a read is active; zero otherwise.
    always_comb begin
        dq_oe  = rd_act;
        dq_out = rd_act ? rdata : '0;
    end

endmodule

// File: rtl/hbi_checker.sv
// Temporal checks for the adaptive host register port, bound to the top.
module hbi_checker
    import hbi_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              dq_oe,
    input logic              tx_wr_o,
    input logic [DATA_W-1:0] ctrl_o,
    input logic [DATA_W-1:0] evt_i,
    input logic [DATA_W-1:0] status_q,
    input logic              wr_commit,
    input logic              in_cycle,
    input bus_style_e        style
);

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !$past(cs_n, 2)); // R6

    AST_TXWR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_o |=> !tx_wr_o); // R4

    AST_CTRL_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> $stable(ctrl_o)); // R4

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R7

    AST_NO_CLEAR_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |=> ((status_q & $past(status_q)) == $past(status_q))); // R8

    AST_STYLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cycle && $past(in_cycle)) |-> (style == $past(style))); // R2

endmodule

bind adaptive_host_port hbi_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .dq_oe     (dq_oe),
    .tx_wr_o   (tx_wr_o),
    .ctrl_o    (ctrl_o),
    .evt_i     (evt_i),
    .status_q  (status_w),
    .wr_commit (wr_commit),
    .in_cycle  (in_cycle),
    .style     (style)
);

// File: tb/tb_adaptive_host_port.sv
module tb_adaptive_host_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       ds_rd = 1'b1;
    logic       wr_rw = 1'b1;
    logic       ale = 1'b0;
    logic [1:0] rsel = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic       dq_oe;
    logic [7:0] ctrl_o;
    logic [7:0] tx_data_o;
    logic       tx_wr_o;
    logic [7:0] rx_data_i = '0;
    logic       rx_load_i = 1'b0;
    logic [7:0] evt_i = '0;

    int checks = 0;
    int failures = 0;
    int tx_pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adaptive_host_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_rd(ds_rd), .wr_rw(wr_rw),
        .ale(ale), .rsel(rsel), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .ctrl_o(ctrl_o), .tx_data_o(tx_data_o), .tx_wr_o(tx_wr_o),
        .rx_data_i(rx_data_i), .rx_load_i(rx_load_i), .evt_i(evt_i)
    );

    always @(posedge clk) if (rst_n && tx_wr_o) tx_pulses++;

    // {split_style, muxed, write, addr[1:0], wdata[7:0], expect[7:0]}
    localparam int NV = 12;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b1, 2'd1, 8'h5A, 8'h5A},
        {1'b1, 1'b0, 1'b0, 2'd1, 8'h00, 8'h5A},
        {1'b0, 1'b0, 1'b1, 2'd1, 8'hC3, 8'hC3},
        {1'b0, 1'b0, 1'b0, 2'd1, 8'h00, 8'hC3},
        {1'b1, 1'b1, 1'b1, 2'd1, 8'h96, 8'h96},
        {1'b0, 1'b1, 1'b0, 2'd1, 8'h00, 8'h96},
        {1'b0, 1'b1, 1'b1, 2'd0, 8'h3C, 8'h3C},
        {1'b1, 1'b1, 1'b0, 2'd3, 8'h00, 8'h00},
        {1'b1, 1'b0, 1'b1, 2'd0, 8'hA5, 8'hA5},
        {1'b0, 1'b0, 1'b0, 2'd3, 8'h00, 8'h00},
        {1'b0, 1'b1, 1'b1, 2'd2, 8'hFF, 8'h00},
        {1'b1, 1'b0, 1'b0, 2'd2, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One host access; mid_evt is pulsed on evt_i while the strobe is held.
    task automatic bus_cycle(input bit split, input bit mux, input bit wr,
                             input logic [1:0] addr, input logic [7:0] wdata,
                             input logic [7:0] mid_evt,
                             output logic [7:0] rdata, output logic oe,
                             output logic [7:0] rdata_late);
        @(negedge clk);
        ds_rd = split ? 1'b1 : 1'b0;
        wr_rw = split ? 1'b1 : ~wr;
        ale   = mux;
        rsel  = mux ? ~addr : addr;
        dq_in = mux ? {6'b101100, addr} : {6'b111000, ~addr};
        idle_clk(4);
        cs_n = 1'b0;
        idle_clk(4);
        ale   = 1'b0;
        dq_in = wr ? wdata : 8'h00;
        if (split) begin
            if (wr) wr_rw = 1'b0;
            else    ds_rd = 1'b0;
        end else begin
            ds_rd = 1'b1;
        end
        idle_clk(3);
        if (mid_evt != 0) begin
            evt_i = mid_evt;
            idle_clk(1);
            evt_i = '0;
        end
        idle_clk(3);
        rdata = dq_out;
        oe    = dq_oe;
        idle_clk(3);
        rdata_late = dq_out;
        if (split) begin
            ds_rd = 1'b1;
            wr_rw = 1'b1;
        end else begin
            ds_rd = 1'b0;
        end
        idle_clk(4);
        cs_n = 1'b1;
        idle_clk(5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] rd2;
        logic       oe;
        idle_clk(4);
        rst_n = 1'b1;
        idle_clk(2);
        // R1 reset state
        chk("R1 dq_oe", {7'b0, dq_oe}, 8'h00);
        chk("R1 tx_wr", {7'b0, tx_wr_o}, 8'h00);
        chk("R1 ctrl", ctrl_o, 8'h00);
        chk("R1 tx_data", tx_data_o, 8'h00);

        // Vector table: R2 styles, R3 address schemes, R4 writes, R5 reads, R7 status write ignored
        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VEC[i];
            bus_cycle(v[20], v[19], v[18], v[17:16], v[15:8], 8'h00, rd, oe, rd2);
            if (v[18]) begin
                chk("R2/R3 write no drive", {7'b0, oe}, 8'h00);
                if (v[17:16] == 2'd0) chk("R4 tx_data", tx_data_o, v[7:0]);
                if (v[17:16] == 2'd1) chk("R4 ctrl", ctrl_o, v[7:0]);
            end else begin
                chk("R6 read drive", {7'b0, oe}, 8'h01);
                chk("R5 R3 read data", rd, v[7:0]);
            end
        end
        chk("R4 tx pulses", 8'(tx_pulses), 8'd2);
        chk("R7 write to status ignored, ctrl kept", ctrl_o, 8'h96);

        // R6: strobes with chip select high do nothing
        @(negedge clk);
        ds_rd = 1'b0; wr_rw = 1'b0; rsel = 2'd1; dq_in = 8'h11;
        idle_clk(6);
        chk("R6 no drive without cs", {7'b0, dq_oe}, 8'h00);
        ds_rd = 1'b1; wr_rw = 1'b0;
        idle_clk(6);
        ds_rd = 1'b0; wr_rw = 1'b1;
        idle_clk(6);
        chk("R6 no write without cs", ctrl_o, 8'h96);
        chk("R6 no tx pulse without cs", 8'(tx_pulses), 8'd2);

        // R9 receive byte
        @(negedge clk);
        rx_data_i = 8'h77; rx_load_i = 1'b1;
        idle_clk(1);
        rx_load_i = 1'b0; rx_data_i = 8'h00;
        bus_cycle(1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, rd, oe, rd2);
        chk("R9 receive read", rd, 8'h77);

        // R7 flags set without any host activity
        @(negedge clk);
        evt_i = 8'h05;
        idle_clk(1);
        evt_i = 8'h00;
        idle_clk(10);
        bus_cycle(1'b0, 1'b0, 1'b0, 2'd2, 8'h00, 8'h00, rd, oe, rd2);
        chk("R7 sticky flags", rd, 8'h05);
        chk("R8 flags visible until strobe end", rd2, 8'h05);
        bus_cycle(1'b1, 1'b1, 1'b0, 2'd2, 8'h00, 8'h00, rd, oe, rd2);
        chk("R8 cleared after read", rd, 8'h00);

        // R8 flag raised during a status read survives it
        @(negedge clk);
        evt_i = 8'h01;
        idle_clk(1);
        evt_i = 8'h00;
        bus_cycle(1'b1, 1'b0, 1'b0, 2'd2, 8'h00, 8'h80, rd, oe, rd2);
        chk("R8 both flags seen during read", rd, 8'h81);
        bus_cycle(1'b0, 1'b1, 1'b0, 2'd2, 8'h00, 8'h00, rd, oe, rd2);
        chk("R8 late flag kept", rd, 8'h80);
        bus_cycle(1'b0, 1'b0, 1'b0, 2'd2, 8'h00, 8'h00, rd, oe, rd2);
        chk("R8 late flag cleared by its own read", rd, 8'h00);

        // R1 reset again clears state
        @(negedge clk);
        rst_n = 1'b0;
        idle_clk(2);
        rst_n = 1'b1;
        idle_clk(2);
        chk("R1 ctrl after reset", ctrl_o, 8'h00);
        chk("R1 tx_data after reset", tx_data_o, 8'h00);
        bus_cycle(1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, rd, oe, rd2);
        chk("R1 receive byte after reset", rd, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule